// File: doc/BRIEF.md
# Bounded Decimal Occupancy Counter

This block keeps a running count of occupied spaces in a facility. A single-cycle arrival pulse adds one to the count, and a single-cycle departure pulse subtracts one. The count is held as decimal digits, four bits each. By default there are two digits, so the range is 00 to 99. Each digit is a synchronous up/down decade stage. A digit only steps when the digit below it rolls over: from 9 to 0 when counting up, or from 0 to 9 when counting down. The lowest digit steps whenever the count moves.

A small state machine tracks where the count sits in its range. It has three states:

- `OCC_EMPTY`: the count is zero.
- `OCC_PARTIAL`: the count is between zero and the capacity.
- `OCC_FULL`: the count equals the configured capacity.

The state machine also decides whether a pulse may move the count. The transitions are:

- `T_FILL`: `OCC_EMPTY` to `OCC_PARTIAL` on an admitted arrival.
- `T_TOP`: `OCC_PARTIAL` or `OCC_EMPTY` to `OCC_FULL` on an arrival from capacity minus one.
- `T_LEAVE`: `OCC_FULL` to `OCC_PARTIAL` on a departure.
- `T_DRAIN`: `OCC_PARTIAL` or `OCC_FULL` to `OCC_EMPTY` on a departure from one.

All other cases hold the current state. The full output comes from the `OCC_FULL` state and can be used to keep an entry gate shut.

Top module: `occupancy_counter`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets count_bcd to 00 and full to 0.
- R2: An arrival pulse alone, when not full, raises the count by one in decimal on the next edge. The low digit is count_bcd[3:0] and the tens digit is count_bcd[7:4]. A low digit of 9 becomes 0 and the tens digit advances.
- R3: A departure pulse alone, when the count is not 00, lowers the count by one in decimal on the next edge. A low digit of 0 becomes 9 and the tens digit drops by one.
- R4: full is 1 exactly when the count equals CAPACITY (default 99, coded as 8'h99). Otherwise it is 0.
- R5: An arrival pulse while full leaves the count and full unchanged.
- R6: A departure pulse while the count is 00 leaves it at 00.
- R7: Arrival and departure pulses in the same cycle leave the count unchanged.
- R8: Every 4-bit digit of count_bcd always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_pulse | input | 1 | One-cycle arrival event |
| exit_pulse | input | 1 | One-cycle departure event |
| count_bcd | output | 4*NUM_DIGITS | Occupancy in decimal digits, low digit in the lowest nibble |
| full | output | 1 | High when the count equals CAPACITY |

## Verification
The hardest situations to reach are the two ends of the range.

- **Full end:** the block must be at exactly 99 with an arrival pending. The bench reaches this by issuing one arrival per cycle from 00 and checking the count against a decimal model at every step. This also exercises every carry from the low digit into the tens digit.
- **Empty end:** departures are sent while the count is 00, and the bench checks that nothing moves.
- **Carry paths:** departures from 10 are used to exercise the borrow path downward.
- **Simultaneous pulses:** arrival and departure are applied together at 00, at 01 and at 99.

// File: rtl/occ_pkg.sv
package occ_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;
endpackage

// File: rtl/occ_bcd_digit.sv
module occ_bcd_digit (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       up,
    output logic [3:0] digit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            digit <= 4'd0;
        end else if (en) begin
            if (up) begin
                digit <= (digit == 4'd9) ? 4'd0 : digit + 4'd1;
            end else begin
                digit <= (digit == 4'd0) ? 4'd9 : digit - 4'd1;
            end
        end
    end
endmodule

// File: rtl/occ_step_select.sv
module occ_step_select
    import occ_pkg::*;
(
    input  logic       entry_pulse,
    input  logic       exit_pulse,
    input  occ_state_t state,
    output step_t      step
);
    always_comb begin
        unique case ({entry_pulse, exit_pulse})
            2'b10:   step = (state == OCC_FULL)  ? STEP_HOLD : STEP_UP;
            2'b01:   step = (state == OCC_EMPTY) ? STEP_HOLD : STEP_DOWN;
            default: step = STEP_HOLD;
        endcase
    end
endmodule

// File: rtl/occupancy_counter.sv
module occupancy_counter
    import occ_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    parameter int CAPACITY   = 99
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    entry_pulse,
    input  logic                    exit_pulse,
    output logic [4*NUM_DIGITS-1:0] count_bcd,
    output logic                    full
);
    localparam int CW = 4 * NUM_DIGITS;

    function automatic logic [CW-1:0] to_bcd(input int v);
        logic [CW-1:0] b;
        int r;
        b = '0;
        r = v;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            b[4*i +: 4] = 4'(r % 10);
            r = r / 10;
        end
        return b;
    endfunction

    localparam logic [CW-1:0] CAP_M1_BCD = to_bcd(CAPACITY - 1);
    localparam logic [CW-1:0] ONE_BCD    = to_bcd(1);

    occ_state_t state, state_nxt;
    step_t      step;
    logic       at_cap_m1, at_one;
    logic [NUM_DIGITS-1:0] dig_en;
    logic       count_up;

    occ_step_select u_sel (
        .entry_pulse (entry_pulse),
        .exit_pulse  (exit_pulse),
        .state       (state),
        .step        (step)
    );

    assign at_cap_m1 = (count_bcd == CAP_M1_BCD);
    assign at_one    = (count_bcd == ONE_BCD);
    assign count_up  = (step == STEP_UP);
    assign dig_en[0] = (step != STEP_HOLD);

    // Cascade: a digit steps when every digit below it rolls over.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        occ_bcd_digit u_digit (
            .clk   (clk),
            .rst   (rst),
            .en    (dig_en[g]),
            .up    (count_up),
            .digit (count_bcd[4*g +: 4])
        );
        if (g < NUM_DIGITS - 1) begin : g_carry
            assign dig_en[g+1] = dig_en[g] &&
                (count_up ? (count_bcd[4*g +: 4] == 4'd9)
                          : (count_bcd[4*g +: 4] == 4'd0));
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OCC_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic: T_FILL, T_TOP, T_LEAVE, T_DRAIN
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: begin
                if (step == STEP_UP) begin
                    state_nxt = at_cap_m1 ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (step == STEP_UP && at_cap_m1) begin
                    state_nxt = OCC_FULL;
                end else if (step == STEP_DOWN && at_one) begin
                    state_nxt = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (step == STEP_DOWN) begin
                    state_nxt = at_one ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: state_nxt = OCC_EMPTY;
        endcase
    end

    // Output logic
    always_comb begin
        full = (state == OCC_FULL);
    end
endmodule

// File: rtl/occ_checker.sv
module occ_checker #(
    parameter int NUM_DIGITS = 2,
    parameter int CAPACITY   = 99
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    entry_pulse,
    input logic                    exit_pulse,
    input logic [4*NUM_DIGITS-1:0] count_bcd,
    input logic                    full
);
    localparam int CW = 4 * NUM_DIGITS;

    function automatic logic [CW-1:0] dec_code(input int v);
        logic [CW-1:0] b;
        int r;
        b = '0;
        r = v;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            b[4*i +: 4] = 4'(r % 10);
            r = r / 10;
        end
        return b;
    endfunction

    localparam logic [CW-1:0] CAP_CODE = dec_code(CAPACITY);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (count_bcd == '0 && !full));

    a_r4_full_at_capacity: assert property (@(posedge clk) disable iff (rst)
        full == (count_bcd == CAP_CODE));

    a_r5_hold_when_full: assert property (@(posedge clk) disable iff (rst)
        (full && entry_pulse && !exit_pulse) |=> ($stable(count_bcd) && full));

    a_r6_hold_at_zero: assert property (@(posedge clk) disable iff (rst)
        (count_bcd == '0 && exit_pulse && !entry_pulse) |=> (count_bcd == '0));

    a_r7_both_no_change: assert property (@(posedge clk) disable iff (rst)
        (entry_pulse && exit_pulse) |=> $stable(count_bcd));

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_legal
        a_r8_digit_legal: assert property (@(posedge clk) disable iff (rst)
            count_bcd[4*g +: 4] <= 4'd9);
    end
endmodule

bind occupancy_counter occ_checker #(
    .NUM_DIGITS (NUM_DIGITS),
    .CAPACITY   (CAPACITY)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .entry_pulse (entry_pulse),
    .exit_pulse  (exit_pulse),
    .count_bcd   (count_bcd),
    .full        (full)
);

// File: tb/occupancy_counter_tb.sv
module occupancy_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       entry_pulse = 1'b0;
    logic       exit_pulse = 1'b0;
    logic [7:0] count_bcd;
    logic       full;

    int checks = 0;
    int failures = 0;
    int occ = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    occupancy_counter u_dut (
        .clk         (clk),
        .rst         (rst),
        .entry_pulse (entry_pulse),
        .exit_pulse  (exit_pulse),
        .count_bcd   (count_bcd),
        .full        (full)
    );

    // Vector: {entry, exit, expected count in decimal digits}
    localparam int NV = 10;
    localparam logic [9:0] VEC [NV] = '{
        {2'b01, 8'h00},   // R6 departure at 00
        {2'b10, 8'h01},   // R2
        {2'b11, 8'h01},   // R7
        {2'b00, 8'h01},
        {2'b10, 8'h02},   // R2
        {2'b01, 8'h01},   // R3
        {2'b01, 8'h00},   // R3
        {2'b01, 8'h00},   // R6
        {2'b11, 8'h00},   // R7 at zero
        {2'b10, 8'h01}    // R2
    };

    function automatic logic [7:0] dec(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts at a falling edge, drives one cycle, returns at the next falling edge.
    task automatic pulse(input logic e, input logic x);
        entry_pulse = e;
        exit_pulse  = x;
        @(negedge clk);
        entry_pulse = 1'b0;
        exit_pulse  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", {full, count_bcd}, {1'b0, 8'h00});

        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][9], VEC[i][8]);
            check("R2/R3/R6/R7 vector", {full, count_bcd}, {1'b0, VEC[i][7:0]});
        end
        occ = 1;

        // Climb to capacity, checking every step and both digits
        while (occ < 99) begin
            pulse(1'b1, 1'b0);
            occ++;
            check("R2 climb", {1'b0, count_bcd}, {1'b0, dec(occ)});
            check("R4 full flag", {8'h00, full}, {8'h00, occ == 99});
            check("R8 digits legal", {1'b0, (count_bcd[3:0] <= 4'd9) && (count_bcd[7:4] <= 4'd9), 7'h0}, {2'b01, 7'h0});
        end

        pulse(1'b1, 1'b0);
        check("R5 arrival while full", {full, count_bcd}, {1'b1, 8'h99});
        pulse(1'b1, 1'b1);
        check("R7 both at full", {full, count_bcd}, {1'b1, 8'h99});
        pulse(1'b0, 1'b1);
        check("R3 leave full", {full, count_bcd}, {1'b0, 8'h98});
        check("R4 not full at 98", {8'h00, full}, {8'h00, 1'b0});

        // Descend to 09 to exercise the borrow from the tens digit
        occ = 98;
        while (occ > 9) begin
            pulse(1'b0, 1'b1);
            occ--;
            check("R3 descend", {full, count_bcd}, {1'b0, dec(occ)});
        end

        // Reset from the middle of the range
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-range", {full, count_bcd}, {1'b0, 8'h00});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule